// File: doc/BRIEF.md
# Serial Byte Transmitter with Level Handshake

This block converts a parallel data word into an asynchronous serial frame on a single output line. The line rests high. A frame is a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. The bit time is set by a clocks-per-bit divisor input, so one build can serve any baud rate the system clock can divide down to.

The host talks to it through a four-phase handshake. It places the word on the data input and raises Send as a held level. The transmitter captures the word and the frame settings and raises Busy in the same cycle. It lowers Busy once the last stop bit has been sent. The host then drops Send. The transmitter will not start another frame until it has seen Send low, so a host that is slow to drop Send never gets a duplicate frame. The usual setting is 8 data bits, no parity and one stop bit.

Top module: `serial_tx_hs`

## Requirements
- R1: After reset, busy is 0 and line_out is 1. A send_lvl that is already high when reset is released does not start a frame until send_lvl has been seen low at least once.
- R2: When send_lvl is high, busy is low and the transmitter is armed, busy rises on the next clock edge and line_out drops to 0 (start bit) on that same edge.
- R3: A frame is sent in this order: one start bit of 0, then the DATA_W data bits with bit 0 first, then the parity bit if enabled, then the stop bits of value 1.
- R4: Every bit of the frame stays on line_out for exactly bit_div clock cycles. A bit_div of 0 is treated as 1.
- R5: When par_en is 1, the parity bit makes the total count of ones over data plus parity even if par_odd is 0, and odd if par_odd is 1. When par_en is 0, no parity bit is sent.
- R6: two_stop = 0 sends one stop bit and two_stop = 1 sends two.
- R7: busy stays high for exactly (1 + DATA_W + parity bits + stop bits) × bit_div cycles and falls on the edge that ends the last stop bit.
- R8: While send_lvl stays high after a frame, no new frame starts. A new frame needs send_lvl to go low and then high again.
- R9: Changes to tx_word, bit_div, par_en, par_odd or two_stop while busy is high do not affect the frame in progress.
- R10: line_out is 1 in every cycle in which busy is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_lvl | input | 1 | Held-level request to send tx_word |
| tx_word | input | DATA_W | Data word to send |
| bit_div | input | DIV_W | Clock cycles per serial bit |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| two_stop | input | 1 | Two stop bits when 1, one when 0 |
| busy | output | 1 | Frame in progress |
| line_out | output | 1 | Serial line, idles high |

## Verification
The bound checker watches several rules on every cycle. It checks that the line is high whenever Busy is low, that each rise of Busy comes with a low start bit and a high Send, that Busy never rises again without Send having been low since the last frame, and that the final cycle of every frame is a high stop bit. The bench scenarios are needed for the rest: bit order, the parity value, the stop count, the exact length of each bit and of the whole frame, the divisor-zero case, and the fact that changes to the inputs during a frame have no effect. These need the expected frame, and only the bench's model supplies it.

// File: rtl/serial_tx_hs_pkg.sv
package serial_tx_hs_pkg;

    typedef enum logic [1:0] {
        PH_START  = 2'd0,
        PH_DATA   = 2'd1,
        PH_PARITY = 2'd2,
        PH_STOP   = 2'd3
    } tx_phase_t;

    typedef struct packed {
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

    // parity bit that brings the ones count to the requested polarity
    function automatic logic calc_parity(input logic [63:0] word, input int unsigned width,
                                         input logic odd);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < 64; i++) begin
            if (i < int'(width)) acc = acc ^ word[i];
        end
        return acc ^ odd;
    endfunction

endpackage

// File: rtl/serial_tx_arm.sv
module serial_tx_arm (
    input  logic clk,
    input  logic rst,
    input  logic send_lvl,
    input  logic busy,
    output logic start
);
    logic armed_q;

    assign start = send_lvl && armed_q && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (start) begin
            armed_q <= 1'b0;
        end else if (!send_lvl) begin
            armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/serial_tx_baud.sv
module serial_tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] bit_div,
    output logic             tick
);
    logic [DIV_W-1:0] period_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] period_eff;

    assign period_eff = (bit_div == '0) ? DIV_W'(1) : bit_div;
    assign tick       = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= DIV_W'(1);
            cnt_q    <= '0;
        end else if (load) begin
            period_q <= period_eff;
            cnt_q    <= period_eff - DIV_W'(1);
        end else if (run) begin
            if (cnt_q == '0) cnt_q <= period_q - DIV_W'(1);
            else             cnt_q <= cnt_q - DIV_W'(1);
        end
    end
endmodule

// File: rtl/serial_tx_shift.sv
module serial_tx_shift
    import serial_tx_hs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              tick,
    input  logic [DATA_W-1:0] word,
    input  frame_cfg_t        cfg,
    output logic              busy,
    output logic              line_out
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_phase_t         phase_q;
    frame_cfg_t        cfg_q;
    logic [DATA_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic              par_q;
    logic              stop_idx_q;
    logic              busy_q;
    logic              line_q;

    assign busy     = busy_q;
    assign line_out = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_START;
            cfg_q      <= '0;
            shreg_q    <= '0;
            idx_q      <= '0;
            par_q      <= 1'b0;
            stop_idx_q <= 1'b0;
            busy_q     <= 1'b0;
            line_q     <= 1'b1;
        end else if (load) begin
            phase_q    <= PH_START;
            cfg_q      <= cfg;
            shreg_q    <= word;
            idx_q      <= '0;
            par_q      <= calc_parity(64'(word), DATA_W, cfg.par_odd);
            stop_idx_q <= 1'b0;
            busy_q     <= 1'b1;
            line_q     <= 1'b0;
        end else if (busy_q && tick) begin
            unique case (phase_q)
                PH_START: begin
                    phase_q <= PH_DATA;
                    line_q  <= shreg_q[0];
                    shreg_q <= shreg_q >> 1;
                    idx_q   <= '0;
                end
                PH_DATA: begin
                    if (idx_q == IDX_W'(DATA_W - 1)) begin
                        if (cfg_q.par_en) begin
                            phase_q <= PH_PARITY;
                            line_q  <= par_q;
                        end else begin
                            phase_q    <= PH_STOP;
                            line_q     <= 1'b1;
                            stop_idx_q <= 1'b0;
                        end
                    end else begin
                        line_q  <= shreg_q[0];
                        shreg_q <= shreg_q >> 1;
                        idx_q   <= idx_q + IDX_W'(1);
                    end
                end
                PH_PARITY: begin
                    phase_q    <= PH_STOP;
                    line_q     <= 1'b1;
                    stop_idx_q <= 1'b0;
                end
                PH_STOP: begin
                    if (stop_idx_q == cfg_q.two_stop) begin
                        busy_q  <= 1'b0;
                        line_q  <= 1'b1;
                        phase_q <= PH_START;
                    end else begin
                        stop_idx_q <= 1'b1;
                    end
                end
                default: phase_q <= PH_START;
            endcase
        end
    end
endmodule

// File: rtl/serial_tx_hs.sv
module serial_tx_hs
    import serial_tx_hs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              send_lvl,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [DIV_W-1:0]  bit_div,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    output logic              busy,
    output logic              line_out
);
    logic       start;
    logic       tick;
    frame_cfg_t cfg;

    assign cfg = '{par_en: par_en, par_odd: par_odd, two_stop: two_stop};

    serial_tx_arm u_arm (
        .clk      (clk),
        .rst      (rst),
        .send_lvl (send_lvl),
        .busy     (busy),
        .start    (start)
    );

    serial_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst     (rst),
        .load    (start),
        .run     (busy),
        .bit_div (bit_div),
        .tick    (tick)
    );

    serial_tx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .tick     (tick),
        .word     (tx_word),
        .cfg      (cfg),
        .busy     (busy),
        .line_out (line_out)
    );
endmodule

// File: rtl/serial_tx_hs_chk.sv
module serial_tx_hs_chk (
    input logic clk,
    input logic rst,
    input logic send_lvl,
    input logic busy,
    input logic line_out
);
    logic low_seen_q;
    logic started_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_seen_q <= 1'b0;
            started_q  <= 1'b0;
        end else begin
            low_seen_q <= !send_lvl || (low_seen_q && !busy);
            started_q  <= 1'b1;
        end
    end

    p_idle_line_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> line_out);

    p_start_bit_r2: assert property (@(posedge clk) disable iff (rst)
        (started_q && $rose(busy)) |-> !line_out);

    p_rise_needs_send_r2: assert property (@(posedge clk) disable iff (rst)
        (started_q && $rose(busy)) |-> $past(send_lvl));

    p_rearm_r8: assert property (@(posedge clk) disable iff (rst)
        (started_q && $rose(busy)) |-> $past(low_seen_q));

    p_stop_tail_r3: assert property (@(posedge clk) disable iff (rst)
        (started_q && $fell(busy)) |-> $past(line_out));
endmodule

bind serial_tx_hs serial_tx_hs_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .send_lvl (send_lvl),
    .busy     (busy),
    .line_out (line_out)
);

// File: tb/serial_tx_hs_test.sv
`timescale 1ns/1ps
module serial_tx_hs_test;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 16;
    localparam int NVEC   = 6;

    // {word, divisor, par_en, par_odd, two_stop}
    localparam logic [26:0] VEC [NVEC] = '{
        {8'h57, 16'd1, 1'b0, 1'b0, 1'b0},
        {8'hA5, 16'd2, 1'b1, 1'b0, 1'b0},
        {8'h3C, 16'd3, 1'b1, 1'b1, 1'b1},
        {8'hFF, 16'd4, 1'b1, 1'b0, 1'b1},
        {8'h00, 16'd5, 1'b1, 1'b1, 1'b0},
        {8'h81, 16'd2, 1'b0, 1'b0, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              send_lvl = 1'b0;
    logic [DATA_W-1:0] tx_word = '0;
    logic [DIV_W-1:0]  bit_div = 16'd1;
    logic              par_en = 1'b0;
    logic              par_odd = 1'b0;
    logic              two_stop = 1'b0;
    logic              busy;
    logic              line_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    serial_tx_hs #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uut (
        .clk(clk), .rst(rst), .send_lvl(send_lvl), .tx_word(tx_word),
        .bit_div(bit_div), .par_en(par_en), .par_odd(par_odd),
        .two_stop(two_stop), .busy(busy), .line_out(line_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input int idx, input logic [7:0] w,
                                     input logic pe, input logic po);
        if (idx == 0) return 1'b0;
        if (idx <= DATA_W) return w[idx-1];
        if (pe && idx == DATA_W + 1) return (^w) ^ po;
        return 1'b1;
    endfunction

    // sends one frame and checks every cycle of it; disturb scrambles inputs mid-frame
    task automatic run_frame(input logic [7:0] w, input int d, input logic pe,
                             input logic po, input logic ts, input bit disturb,
                             input string tag);
        int dd, nbits, i, bad_i;
        logic bad_act;
        bit bad;
        dd    = (d == 0) ? 1 : d;
        nbits = 1 + DATA_W + (pe ? 1 : 0) + (ts ? 2 : 1);
        tx_word = w; bit_div = DIV_W'(d); par_en = pe; par_odd = po; two_stop = ts;
        send_lvl = 1'b1;
        @(negedge clk);
        check(busy === 1'b1 && line_out === 1'b0, "R2 busy and start bit",
              {busy, line_out}, 2);
        i = 0; bad = 0; bad_i = 0; bad_act = 0;
        while (busy === 1'b1 && i < 4000) begin
            if (!bad && line_out !== exp_bit(i / dd, w, pe, po)) begin
                bad = 1; bad_i = i; bad_act = line_out;
            end
            if (disturb && i == 2) begin
                tx_word = ~w; bit_div = DIV_W'(dd + 3); par_en = ~pe;
                par_odd = ~po; two_stop = ~ts;
            end
            @(negedge clk);
            i++;
        end
        check(!bad, {tag, " R3/R4/R5 frame bits"}, int'(bad_act),
              int'(exp_bit(bad_i / dd, w, pe, po)));
        check(i == nbits * dd, {tag, " R6/R7 busy length"}, i, nbits * dd);
        check(line_out === 1'b1, "R10 line high after frame", int'(line_out), 1);
    endtask

    initial begin
        send_lvl = 1'b1;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && line_out === 1'b1, "R1 reset state", {busy, line_out}, 1);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        check(busy === 1'b0 && line_out === 1'b1, "R1 held send ignored after reset",
              {busy, line_out}, 1);
        send_lvl = 1'b0;
        @(negedge clk);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            run_frame(VEC[v][26:19], int'(VEC[v][18:3]), VEC[v][2], VEC[v][1],
                      VEC[v][0], 1'b0, "table");
            send_lvl = 1'b0;
            @(negedge clk);
        end

        // R8: send kept high after frame does not restart
        run_frame(8'h5A, 2, 1'b0, 1'b0, 1'b0, 1'b0, "R8 pre");
        begin
            bit restarted;
            restarted = 0;
            for (int k = 0; k < 40; k++) begin
                if (busy !== 1'b0 || line_out !== 1'b1) restarted = 1;
                @(negedge clk);
            end
            check(!restarted, "R8 no restart while send high", int'(restarted), 0);
        end
        send_lvl = 1'b0;
        @(negedge clk);
        check(busy === 1'b0, "R8 idle after send low", int'(busy), 0);
        run_frame(8'hC3, 1, 1'b1, 1'b0, 1'b0, 1'b0, "R8 rearm");
        send_lvl = 1'b0;
        @(negedge clk);

        // R4: divisor zero behaves as one
        run_frame(8'h96, 0, 1'b1, 1'b1, 1'b0, 1'b0, "R4 div0");
        send_lvl = 1'b0;
        @(negedge clk);

        // R9: inputs scrambled mid-frame
        run_frame(8'h6E, 3, 1'b1, 1'b0, 1'b1, 1'b1, "R9 disturb");
        send_lvl = 1'b0;
        @(negedge clk);
        run_frame(8'h12, 2, 1'b0, 1'b1, 1'b0, 1'b1, "R9 disturb2");
        send_lvl = 1'b0;
        @(negedge clk);

        // R1: reset during a frame returns to idle
        tx_word = 8'h00; bit_div = 16'd4; par_en = 0; two_stop = 0;
        send_lvl = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && line_out === 1'b1, "R1 reset mid-frame",
              {busy, line_out}, 1);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(busy === 1'b0, "R1 no start without low after reset", int'(busy), 0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule